// File: doc/BRIEF.md
# Protection violation status capture

This block keeps the record of CPU access violations for a memory protection unit. Each cycle it may receive a violation strobe along with its cause, the CPU privilege state and the violating address. The cause is a write to read-only memory, an instruction fetch from no-execute memory, or an access to an address that no descriptor covers. On the first violation it raises an error flag. It also freezes a snapshot of the cause, the privilege and the address. That snapshot stays untouched until software clears the flag.

Software reaches the block through a small byte-wide register port. Offset 0 holds the flag register. Offsets 1 to 3 hold the captured address, most significant byte first. The error interrupt is a level output. Another output tells the bus fabric that a supervisor-state CPU may reach the peripheral register space without a matching descriptor while the flag is set. With that access, software can always clear the flag.

Top module: `mpu_viol_status`

## Requirements
- R1: After reset the flag register (offset 0) and all three address bytes (offsets 1, 2, 3) read 0x00, and `irq_o` and `sup_bypass_o` are 0.
- R2: When the error flag is clear, a cycle with `viol_i` high sets the error flag, flag register bit 7, from the next cycle on. In the same update it loads bit 6 from `viol_wp_i`, bit 5 from `viol_nx_i` and bit 0 from `cpu_sup_i`. Bit 0 is 1 for supervisor state and 0 for user state.
- R3: A capture with both `viol_wp_i` and `viol_nx_i` low stores bits 6 and 5 as 0. This pattern marks an access to memory covered by no descriptor.
- R4: The captured address is readable as offset 1 = address bits 22:16 with bit 7 of that byte reading 0, offset 2 = bits 15:8 and offset 3 = bits 7:0.
- R5: While the error flag is set, further violations change neither bits 6, 5 and 0 nor the captured address.
- R6: A register write to offset 0 with data bit 7 = 1 clears the error flag. With data bit 7 = 0 the write changes nothing. Bits 6, 5 and 0 cannot be written and keep their captured values after a clear.
- R7: If a violation arrives in the same cycle as a clearing write, the violation wins. The flag stays set and the new cause, privilege and address are captured.
- R8: `irq_o` is high in every cycle in which `viol_i` is high, whether the flag is set or not. It is also high in every cycle in which the error flag is set.
- R9: `sup_bypass_o` is high exactly when the error flag is set and `cpu_sup_i` is high.
- R10: Flag register bits 4 to 1 always read 0. Writes to offsets 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| viol_i | input | 1 | CPU access violation strobe, one per violating cycle |
| viol_wp_i | input | 1 | Violation cause: write to read-only memory |
| viol_nx_i | input | 1 | Violation cause: fetch from no-execute memory |
| cpu_sup_i | input | 1 | CPU is in supervisor state |
| viol_addr_i | input | 23 | Address of the violating access |
| reg_addr_i | input | 2 | Register port byte offset |
| reg_wr_i | input | 1 | Register port write strobe |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data, combinational on the offset |
| irq_o | output | 1 | Access error interrupt request, level |
| sup_bypass_o | output | 1 | Supervisor peripheral register access granted without descriptor |

## Verification
The bench builds the block with its default address width of 23. At that width the top address byte is only partly filled, so the bench can show that the unused upper bit reads zero. Violations are presented at distinct addresses with walking bit patterns. Any byte swap or stale capture therefore shows in the address reads. The bench times a violation into the exact cycle of a clearing write. It also repeats violations while the flag is held, which exposes a wrong priority and a leaking snapshot.

// File: rtl/mpu_stat_pkg.sv
package mpu_stat_pkg;
  localparam int unsigned FLG_AEF_BIT = 7;
  localparam int unsigned FLG_WP_BIT  = 6;
  localparam int unsigned FLG_NX_BIT  = 5;
  localparam int unsigned FLG_SUP_BIT = 0;

  typedef struct packed {
    logic wp;
    logic nx;
    logic sup;
  } viol_cause_t;
endpackage

// File: rtl/mpu_rst_sync.sv
module mpu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/mpu_viol_capture.sv
module mpu_viol_capture
  import mpu_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              viol_i,
  input  viol_cause_t       cause_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              aef_o,
  output viol_cause_t       cause_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              aef_q, aef_d;
  viol_cause_t       cause_q, cause_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load;

  always_comb begin
    load    = viol_i & (~aef_q | clr_i);
    cause_d = cause_q;
    addr_d  = addr_q;
    if (load) begin
      aef_d   = 1'b1;
      cause_d = cause_i;
      addr_d  = addr_i;
    end else if (clr_i) begin
      aef_d   = 1'b0;
    end else begin
      aef_d   = aef_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      aef_q   <= 1'b0;
      cause_q <= '0;
      addr_q  <= '0;
    end else begin
      aef_q <= aef_d;
      if (load) begin
        cause_q <= cause_d;
        addr_q  <= addr_d;
      end
    end
  end

  assign aef_o   = aef_q;
  assign cause_o = cause_q;
  assign addr_o  = addr_q;

  // R2
  viol_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    viol_i |=> aef_q);

  // R5
  hold_while_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (aef_q && !clr_i) |=> ($stable(cause_q) && $stable(addr_q)));

  // R6
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_i && !viol_i) |=> !aef_q);

  // R7
  viol_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_i && viol_i) |=> (aef_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/mpu_reg_port.sv
module mpu_reg_port
  import mpu_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  localparam int unsigned NBYTES = (ADDR_W + 7) / 8,
  localparam int unsigned RA_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              aef_i,
  input  viol_cause_t       cause_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              clr_o
);
  localparam int unsigned PAD_W = NBYTES * 8;

  logic [PAD_W-1:0] addr_pad;
  logic [7:0]       flag_byte;
  logic [7:0]       byte_rd [NBYTES+1];

  always_comb begin
    addr_pad = '0;
    addr_pad[ADDR_W-1:0] = addr_i;
    flag_byte = '0;
    flag_byte[FLG_AEF_BIT] = aef_i;
    flag_byte[FLG_WP_BIT]  = cause_i.wp;
    flag_byte[FLG_NX_BIT]  = cause_i.nx;
    flag_byte[FLG_SUP_BIT] = cause_i.sup;
  end

  assign byte_rd[0] = flag_byte;

  genvar k;
  generate
    for (k = 1; k <= NBYTES; k++) begin : g_abyte
      assign byte_rd[k] = addr_pad[(NBYTES-k)*8 +: 8];
    end
  endgenerate

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i <= NBYTES; i++) begin
      if (reg_addr_i == RA_W'(i)) reg_rdata_o = byte_rd[i];
    end
  end

  assign clr_o = reg_wr_i & (reg_addr_i == '0) & reg_wdata_i[FLG_AEF_BIT];

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_addr_i == '0) |-> (reg_rdata_o[4:1] == 4'b0000));
endmodule

// File: rtl/mpu_irq_gen.sv
module mpu_irq_gen (
  input  logic clk,
  input  logic rst_sn,
  input  logic aef_i,
  input  logic viol_i,
  input  logic cpu_sup_i,
  output logic irq_o,
  output logic sup_bypass_o
);
  always_comb begin
    irq_o        = aef_i | viol_i;
    sup_bypass_o = aef_i & cpu_sup_i;
  end

  // R8
  irq_on_viol_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    viol_i |-> irq_o);

  // R9
  bypass_needs_sup_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    sup_bypass_o |-> cpu_sup_i);
endmodule

// File: rtl/mpu_viol_status.sv
module mpu_viol_status
  import mpu_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  localparam int unsigned NBYTES = (ADDR_W + 7) / 8,
  localparam int unsigned RA_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_i,
  input  logic              viol_wp_i,
  input  logic              viol_nx_i,
  input  logic              cpu_sup_i,
  input  logic [ADDR_W-1:0] viol_addr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              sup_bypass_o
);
  logic              rst_sn;
  logic              clr;
  logic              aef;
  viol_cause_t       cause_in;
  viol_cause_t       cause_q;
  logic [ADDR_W-1:0] addr_q;

  assign cause_in = '{wp: viol_wp_i, nx: viol_nx_i, sup: cpu_sup_i};

  mpu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mpu_viol_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .viol_i  (viol_i),
    .cause_i (cause_in),
    .addr_i  (viol_addr_i),
    .clr_i   (clr),
    .aef_o   (aef),
    .cause_o (cause_q),
    .addr_o  (addr_q)
  );

  mpu_reg_port #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .aef_i       (aef),
    .cause_i     (cause_q),
    .addr_i      (addr_q),
    .clr_o       (clr)
  );

  mpu_irq_gen u_irq (
    .clk          (clk),
    .rst_sn       (rst_sn),
    .aef_i        (aef),
    .viol_i       (viol_i),
    .cpu_sup_i    (cpu_sup_i),
    .irq_o        (irq_o),
    .sup_bypass_o (sup_bypass_o)
  );
endmodule

// File: tb/mpu_viol_status_tb.sv
`timescale 1ns/100ps
module mpu_viol_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        viol_i, viol_wp_i, viol_nx_i, cpu_sup_i;
  logic [22:0] viol_addr_i;
  logic [1:0]  reg_addr_i;
  logic        reg_wr_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic        irq_o, sup_bypass_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  mpu_viol_status u_dut (
    .clk(clk), .rst_n(rst_n), .viol_i(viol_i), .viol_wp_i(viol_wp_i),
    .viol_nx_i(viol_nx_i), .cpu_sup_i(cpu_sup_i), .viol_addr_i(viol_addr_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .sup_bypass_o(sup_bypass_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #0.2;
    d = reg_rdata_o;
  endtask

  task automatic chk_addr(input string req, input logic [22:0] exp);
    logic [7:0] b1, b2, b3;
    rd(2'd1, b1); rd(2'd2, b2); rd(2'd3, b3);
    check(req, {b1, b2, b3}, {1'b0, exp});
  endtask

  task automatic chk_flag(input string req, input logic [7:0] exp);
    logic [7:0] f;
    rd(2'd0, f);
    check(req, f, exp);
  endtask

  // drive a violation for one cycle, starting and ending at a negedge
  task automatic viol(input logic wp, input logic nx, input logic sup, input logic [22:0] a);
    viol_i = 1'b1; viol_wp_i = wp; viol_nx_i = nx; cpu_sup_i = sup; viol_addr_i = a;
    #0.2;
    check("R8 irq during violation", irq_o, 1'b1);
    @(negedge clk);
    viol_i = 1'b0; viol_wp_i = 1'b0; viol_nx_i = 1'b0; cpu_sup_i = 1'b0; viol_addr_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic t_reset;
    chk_flag("R1 flag after reset", 8'h00);
    chk_addr("R1 address after reset", 23'h0);
    check("R1 irq after reset", irq_o, 1'b0);
    check("R1 bypass after reset", sup_bypass_o, 1'b0);
  endtask

  task automatic t_first_capture;
    viol(1'b1, 1'b0, 1'b0, 23'h5A_3C_81);
    chk_flag("R2 write-protect user capture", 8'hC0);
    chk_addr("R4 address bytes", 23'h5A_3C_81);
    check("R8 irq while flag set", irq_o, 1'b1);
  endtask

  task automatic t_hold;
    viol(1'b0, 1'b1, 1'b1, 23'h12_3456);
    chk_flag("R5 cause held", 8'hC0);
    chk_addr("R5 address held", 23'h5A_3C_81);
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h7F);
    chk_flag("R6 write 0 to bit7 ignored", 8'hC0);
    wr(2'd0, 8'h80);
    chk_flag("R6 clear keeps cause", 8'h40);
    check("R8 irq low after clear", irq_o, 1'b0);
  endtask

  task automatic t_nx_sup;
    viol(1'b0, 1'b1, 1'b1, 23'h7F_FFFF);
    chk_flag("R2 no-exec supervisor capture", 8'hA1);
    chk_addr("R4 top bit byte", 23'h7F_FFFF);
    wr(2'd0, 8'hFF);
    chk_flag("R6 clear with all ones", 8'h21);
  endtask

  task automatic t_uncovered;
    viol(1'b0, 1'b0, 1'b0, 23'h00_0001);
    chk_flag("R3 uncovered capture", 8'h80);
    chk_addr("R3 uncovered address", 23'h00_0001);
  endtask

  task automatic t_simul;
    // flag is set here; violation and clear in the same cycle
    viol_i = 1'b1; viol_wp_i = 1'b1; viol_nx_i = 1'b0; cpu_sup_i = 1'b1;
    viol_addr_i = 23'h2A_AAAA;
    reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h80;
    @(negedge clk);
    viol_i = 1'b0; viol_wp_i = 1'b0; cpu_sup_i = 1'b0; viol_addr_i = '0;
    reg_wr_i = 1'b0; reg_wdata_i = '0;
    chk_flag("R7 violation beats clear", 8'hC1);
    chk_addr("R7 new address captured", 23'h2A_AAAA);
  endtask

  task automatic t_bypass;
    cpu_sup_i = 1'b1; #0.2;
    check("R9 bypass flag set supervisor", sup_bypass_o, 1'b1);
    cpu_sup_i = 1'b0; #0.2;
    check("R9 bypass flag set user", sup_bypass_o, 1'b0);
    @(negedge clk);
    wr(2'd0, 8'h80);
    cpu_sup_i = 1'b1; #0.2;
    check("R9 bypass flag clear", sup_bypass_o, 1'b0);
    cpu_sup_i = 1'b0;
  endtask

  task automatic t_reserved;
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h00);
    chk_addr("R10 address bytes not writable", 23'h2A_AAAA);
    wr(2'd0, 8'h1E);
    chk_flag("R10 reserved bits zero", 8'h41);
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    viol_i = 1'b0; viol_wp_i = 1'b0; viol_nx_i = 1'b0; cpu_sup_i = 1'b0;
    viol_addr_i = '0; reg_addr_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_first_capture;
    t_hold;
    t_clear;
    t_nx_sup;
    t_uncovered;
    t_simul;
    t_bypass;
    t_reserved;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule